// File: doc/BRIEF.md
# Single-Channel PWM with Staged Settings and Commit Flag

This block makes one pulse-width-modulated output from a single 32-bit control word. Software writes the word through a plain write port, and a read port returns it. The written frequency step and duty threshold go into a staging copy. The running waveform keeps its current settings until a write sets the commit flag. A committed change is then picked up at the next period boundary, so a period in progress is never cut short. When the output is disabled, or when the committed step is zero and the counter cannot reach a boundary, the change is picked up at once.

The waveform comes from a 16-bit phase accumulator. While enabled, it adds the active step on every clock, so the output frequency is clk × step / 65536. The duty threshold is stored in inverted form: it is 255 minus the wanted high fraction scaled to 0..255. The output is high while the upper byte of the phase is at or above the threshold. Readback shows the staged fields, not the running ones, so a value read back may not yet be applied. The commit flag stays visible until the transfer is done.

Top module: `pwm_commit_top`

## Requirements
- R1: After synchronous reset, `rd_data` is 0 and `pwm_out` is low.
- R2: The control word holds the threshold in bits 7:0, the step in bits 23:8, the commit flag in bit 30 and the enable in bit 31. Bits 29:24 are ignored on write and read as 0.
- R3: A write with bit 30 clear updates the readback on the next clock. The running step and threshold stay unchanged, and so does the output pattern.
- R4: A write with bit 30 set while enabled reads back with bit 30 at 1. At the first clock edge where the phase accumulator carries out, the staged step and threshold become active and bit 30 reads 0.
- R5: A write with bit 30 set while the stored enable is 0 is applied at the next clock edge, and bit 30 then reads 0.
- R6: While enabled, the phase adds the active step modulo 65536 on every clock. While disabled, the phase is held at 0.
- R7: `pwm_out` is high exactly when the enable is set and phase[15:8] is greater than or equal to the active threshold.
- R8: When the active step is 0, the phase stops and the output holds steady. A pending commit is then applied at the next clock edge.
- R9: A write that clears bits 31 and 30 together drives the output low from the next clock and keeps the active settings. Enabling again without a commit resumes with those settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Staged control word with the pending-commit flag |
| pwm_out | output | 1 | PWM output |

## Verification
A write takes effect in readback at the first clock edge after the strobe. The bench drives at the falling edge and reads back at the next falling edge. A commit made while disabled or stalled clears its flag one edge later. A commit made while running clears its flag at the phase carry, which can come up to 65536/step clocks later, so the bench polls the flag within that bound before it judges the duty. A behavioural model steps on every rising edge and is compared with both outputs at every falling edge. Duty checks count high cycles over whole periods, so they do not depend on phase alignment.

// File: rtl/pwm_commit_pkg.sv
package pwm_commit_pkg;
    localparam int REG_W    = 32;
    localparam int STEP_W   = 16;
    localparam int THR_W    = 8;
    localparam int THR_LSB  = 0;
    localparam int STEP_LSB = THR_LSB + THR_W;
    localparam int RSV_LSB  = STEP_LSB + STEP_W;
    localparam int PEND_BIT = 30;
    localparam int EN_BIT   = 31;

    typedef struct packed {
        logic              en;
        logic              pend;
        logic [STEP_W-1:0] step;
        logic [THR_W-1:0]  thr;
    } ctrl_t;

    function automatic ctrl_t unpack_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.en   = w[EN_BIT];
        c.pend = w[PEND_BIT];
        c.step = w[STEP_LSB +: STEP_W];
        c.thr  = w[THR_LSB +: THR_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]               = c.en;
        w[PEND_BIT]             = c.pend;
        w[STEP_LSB +: STEP_W]   = c.step;
        w[THR_LSB +: THR_W]     = c.thr;
        return w;
    endfunction
endpackage

// File: rtl/pwm_stage_reg.sv
module pwm_stage_reg
    import pwm_commit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             xfer_done,
    output ctrl_t            ctrl_q
);
    logic unused_rsv;
    assign unused_rsv = ^wr_data[PEND_BIT-1:RSV_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (xfer_done) ctrl_q.pend <= 1'b0;
            if (wr_en)     ctrl_q      <= unpack_word(wr_data);
        end
    end

    // R3: staged fields only move on a write
    p_stage_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctrl_q.step) && $stable(ctrl_q.thr) && $stable(ctrl_q.en)));

    // R4: a finished transfer drops the flag unless a new commit arrives
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !(wr_en && wr_data[PEND_BIT])) |=> !ctrl_q.pend);
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
    parameter int STEP_W = pwm_commit_pkg::STEP_W,
    parameter int THR_W  = pwm_commit_pkg::THR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              commit_req,
    input  logic [STEP_W-1:0] staged_step,
    input  logic [THR_W-1:0]  staged_thr,
    output logic [STEP_W-1:0] act_step,
    output logic [THR_W-1:0]  act_thr,
    output logic [STEP_W-1:0] phase,
    output logic              xfer
);
    logic [STEP_W:0] sum;
    logic            carry;
    logic            stalled;

    assign sum     = {1'b0, phase} + {1'b0, act_step};
    assign carry   = sum[STEP_W];
    assign stalled = (act_step == '0);
    assign xfer    = commit_req && (!run || carry || stalled);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            act_step <= '0;
            act_thr  <= '0;
        end else begin
            phase <= run ? sum[STEP_W-1:0] : '0;
            if (xfer) begin
                act_step <= staged_step;
                act_thr  <= staged_thr;
            end
        end
    end

    // R6: phase parked at zero while disabled
    p_idle_phase_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));

    // R8: zero step freezes the phase
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (run && stalled) |=> $stable(phase));

    // R3: active settings only change on a transfer
    p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> ($stable(act_step) && $stable(act_thr)));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
    parameter int PH_W  = pwm_commit_pkg::STEP_W,
    parameter int THR_W = pwm_commit_pkg::THR_W
) (
    input  logic             run,
    input  logic [PH_W-1:0]  phase,
    input  logic [THR_W-1:0] thr,
    output logic             level
);
    localparam int TOP_LSB = PH_W - THR_W;

    logic unused_low;
    assign unused_low = ^phase[TOP_LSB-1:0];

    always_comb begin
        level = run && (phase[PH_W-1:TOP_LSB] >= thr);
    end
endmodule

// File: rtl/pwm_commit_top.sv
module pwm_commit_top
    import pwm_commit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    ctrl_t             ctrl_q;
    logic              xfer;
    logic [STEP_W-1:0] act_step;
    logic [THR_W-1:0]  act_thr;
    logic [STEP_W-1:0] phase;

    pwm_stage_reg u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .xfer_done (xfer),
        .ctrl_q    (ctrl_q)
    );

    pwm_phase_gen #(.STEP_W(STEP_W), .THR_W(THR_W)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .run         (ctrl_q.en),
        .commit_req  (ctrl_q.pend),
        .staged_step (ctrl_q.step),
        .staged_thr  (ctrl_q.thr),
        .act_step    (act_step),
        .act_thr     (act_thr),
        .phase       (phase),
        .xfer        (xfer)
    );

    pwm_duty_cmp #(.PH_W(STEP_W), .THR_W(THR_W)) u_cmp (
        .run   (ctrl_q.en),
        .phase (phase),
        .thr   (act_thr),
        .level (pwm_out)
    );

    assign rd_data = pack_word(ctrl_q);

    // R7: disabled output stays low
    p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_data[EN_BIT] |-> !pwm_out);

    // R5: commit while disabled lands on the next edge
    p_idle_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data[PEND_BIT] && !rd_data[EN_BIT] && !wr_en) |=> !rd_data[PEND_BIT]);

    // R2: reserved bits read back as zero
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[PEND_BIT-1:RSV_LSB] == '0));
endmodule

// File: tb/pwm_commit_top_tb_top.sv
module pwm_commit_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    bit m_en, m_pend;
    int m_step, m_thr, a_step, a_thr, m_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_commit_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic logic [31:0] model_word();
        return {m_en, m_pend, 6'b0, m_step[15:0], m_thr[7:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_pend = 0; m_step = 0; m_thr = 0;
            a_step = 0; a_thr = 0; m_ph = 0;
        end else begin
            int s;
            bit wrap, mv;
            s    = m_ph + a_step;
            wrap = (s >= 65536);
            mv   = m_pend && (!m_en || wrap || a_step == 0);
            m_ph = m_en ? (s % 65536) : 0;
            if (mv) begin a_step = m_step; a_thr = m_thr; m_pend = 0; end
            if (wr_en) begin
                m_en   = wr_data[31];
                m_pend = wr_data[30];
                m_step = wr_data[23:8];
                m_thr  = wr_data[7:0];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_tests++;
            if (rd_data !== model_word()) begin
                n_fail++;
                $display("FAIL R2 R3 readback: got %h exp %h", rd_data, model_word());
            end
            n_tests++;
            if (pwm_out !== (m_en && ((m_ph >> 8) >= a_thr))) begin
                n_fail++;
                $display("FAIL R6 R7 pwm_out: got %b exp %b", pwm_out,
                         (m_en && ((m_ph >> 8) >= a_thr)));
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic count_high(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt += pwm_out;
        end
    endtask

    task automatic wait_commit(input string req);
        int i;
        for (i = 0; i < 70; i++) begin
            if (!rd_data[30]) break;
            @(negedge clk);
        end
        check(req, rd_data[30], 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c;
        logic held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_data", rd_data, 0);
        check("R1 pwm_out", pwm_out, 0);

        write_reg(32'h3F12_3456);
        check("R2 reserved masked", rd_data, 32'h0012_3456);

        write_reg(32'h4004_0080);
        check("R5 flag visible", rd_data, 32'h4004_0080);
        @(negedge clk);
        check("R5 applied next edge", rd_data, 32'h0004_0080);

        write_reg(32'h8004_0080);
        repeat (3) @(negedge clk);
        count_high(64, c);
        check("R6 R7 half duty", c, 32);

        write_reg(32'h8004_0000);
        check("R3 readback", rd_data, 32'h8004_0000);
        count_high(64, c);
        check("R3 active unchanged", c, 32);

        write_reg(32'hC004_0000);
        check("R4 flag set", rd_data[30], 1);
        wait_commit("R4 flag cleared at carry");
        count_high(64, c);
        check("R4 full duty", c, 64);

        write_reg(32'hC008_00C0);
        wait_commit("R4 second commit");
        count_high(64, c);
        check("R6 R7 quarter duty", c, 16);

        write_reg(32'h0008_00C0);
        check("R9 off next clock", pwm_out, 0);
        count_high(10, c);
        check("R9 stays low", c, 0);
        write_reg(32'h8002_0000);
        repeat (2) @(negedge clk);
        count_high(64, c);
        check("R9 resumes old settings", c, 16);

        write_reg(32'hC000_0040);
        wait_commit("R8 zero step commit");
        @(negedge clk);
        held = pwm_out;
        count_high(20, c);
        check("R8 output steady", c, held ? 20 : 0);
        write_reg(32'hC004_0080);
        check("R8 flag pending", rd_data[30], 1);
        @(negedge clk);
        check("R8 applied next edge", rd_data[30], 0);
        repeat (2) @(negedge clk);
        count_high(64, c);
        check("R8 restart half duty", c, 32);

        finish_run();
    end
endmodule